// File: doc/BRIEF.md
# Strobe-Ordered DRAM Cycle Decoder with Refresh Pointer

This block is the device-side control of a reduced DRAM model. A fast clock samples the row strobe, two byte column strobes, write enable, output enable, a multiplexed address bus and a write data bus. From the order in which the strobe edges arrive, the block decides what each row-strobe low period was: an access, a row-strobe-only refresh, a column-before-row refresh, or a hidden refresh. Refreshes of the column-before-row kind take their row from an internal pointer.

The block holds the row and column latches and a small storage array that it writes one byte at a time. It drives read data with a per-byte enable. When the row strobe rises it reports the finished cycle: its kind and the row that was refreshed. A surrounding model uses the report to track which rows were refreshed. A bus-side model uses the enable to decide when the data pins are driven.

Top module: `dram_cycle_ctrl`

## Requirements
- R1: After reset, `dq_oe` is 0, `cyc_done` is 0, `cyc_kind` is 0 (none), and the first column-before-row refresh uses row 0.
- R2: A row-strobe fall with both column strobes high latches the row from `addr`. If a column strobe then falls before the row strobe rises, the cycle is reported as kind 1 (access) with that row. Each row-strobe low period gives exactly one one-cycle `cyc_done` pulse, issued after the row strobe rises.
- R3: Writes follow the byte lanes. `ucas_n` low writes `din[15:8]` and `lcas_n` low writes `din[7:0]`. A lane whose strobe stays high keeps its stored byte.
- R4: In a read (`we_n` high at the column-strobe fall), a lane's data is driven (`dq_oe` bit 1 upper, bit 0 lower) only while `oe_n` is low and that lane's column strobe is low. The data is the stored byte. With `oe_n` high, `dq_oe` is 0.
- R5: A row-strobe low period with no column-strobe fall is reported as kind 2 (row-only refresh) with the latched row. `dq_oe` stays 0 and no storage changes, whatever `we_n`, `oe_n` and `din` are.
- R6: If a column strobe is already low when the row strobe falls, and no access is being held, the cycle is kind 3 (column-before-row refresh). Its row is the pointer value, and the pointer then advances by one modulo the row count. `we_n`, `oe_n` and `din` are ignored: `dq_oe` stays 0 and the storage is unchanged.
- R7: If the column strobes stay low after an access while the row strobe goes high and then low again, the second period is kind 4 (hidden refresh). It uses and advances the pointer as in R6, and `dq_out` and `dq_oe` keep showing the last read data.
- R8: While the row strobe is low, the column address follows `addr` until a column-strobe fall captures it. Later `addr` changes are ignored until both column strobes are high again. A new fall in the same row-strobe period (page mode) then captures a new column.
- R9: Access and row-only cycles do not move the refresh pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper-byte column strobe, active low |
| lcas_n | input | 1 | Lower-byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W (3) | Multiplexed row/column address |
| din | input | 2*LANE_W (16) | Write data |
| dq_out | output | 2*LANE_W (16) | Read data |
| dq_oe | output | 2 | Per-lane drive enable (1 = driven, 0 = high impedance) |
| cyc_done | output | 1 | One-cycle pulse at the end of a row-strobe period |
| cyc_kind | output | 3 | Kind of the last finished cycle (0 none, 1 access, 2 row-only, 3 column-before-row, 4 hidden) |
| cyc_row | output | ROW_BITS (3) | Row refreshed by the last finished cycle |

## Verification
A pin change is captured by the synchroniser on the first rising edge and becomes the compared value on the second. Every decision the block makes (latches, storage, `dq_out`, the report registers and `cyc_done`) takes effect on the third rising edge. `dq_oe` combines registered state with the synchronised strobes, so it settles on that same third edge. The bench changes pins on falling edges and waits four falling edges before it samples. It catches the one-cycle `cyc_done` pulse with a falling-edge monitor, and every cycle it checks against the monitor's count, so a missing or doubled report is seen.

// File: rtl/dram_cyc_pkg.sv
package dram_cyc_pkg;

  typedef enum logic [2:0] {
    CYC_NONE     = 3'd0,
    CYC_ACCESS   = 3'd1,
    CYC_RAS_ONLY = 3'd2,
    CYC_CBR      = 3'd3,
    CYC_HIDDEN   = 3'd4
  } cyc_kind_t;

  function automatic int unsigned wider(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_sync_pipe.sv
module dram_sync_pipe #(
  parameter int unsigned W       = 1,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= {W{RST_VAL}};
      q    <= {W{RST_VAL}};
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/dram_refresh_ptr.sv
module dram_refresh_ptr #(
  parameter int unsigned ROW_BITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                advance,
  output logic [ROW_BITS-1:0] ptr
);

  function automatic logic [ROW_BITS-1:0] ptr_next(input logic [ROW_BITS-1:0] p);
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (advance) ptr <= ptr_next(ptr);
  end

endmodule

// File: rtl/dram_lane_array.sv
module dram_lane_array #(
  parameter int unsigned ROW_BITS = 3,
  parameter int unsigned COL_BITS = 3,
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned LANES    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ROW_BITS-1:0]       row,
  input  logic [COL_BITS-1:0]       col,
  input  logic [LANES-1:0]          lane_act,
  input  logic                      wr_en,
  input  logic [LANES*LANE_W-1:0]   wdata,
  output logic [LANES*LANE_W-1:0]   rdata
);

  localparam int unsigned IDX_W = ROW_BITS + COL_BITS;
  localparam int unsigned WORDS = 1 << IDX_W;

  function automatic logic [IDX_W-1:0] word_idx(input logic [ROW_BITS-1:0] r,
                                                input logic [COL_BITS-1:0] c);
    return {r, c};
  endfunction

  logic [IDX_W-1:0] idx;
  assign idx = word_idx(row, col);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [WORDS];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (lane_act[g] && wr_en) cells[idx] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     rd_q <= '0;
      else if (lane_act[g] && !wr_en) rd_q <= cells[idx];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/dram_cycle_classifier.sv
module dram_cycle_classifier
  import dram_cyc_pkg::*;
#(
  parameter int unsigned ROW_BITS = 3,
  parameter int unsigned COL_BITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_fall,
  input  logic                ras_rise,
  input  logic [1:0]          cas_s,
  input  logic [1:0]          lane_fall,
  input  logic                we_s,
  input  logic [ROW_BITS-1:0] row_pin,
  input  logic [COL_BITS-1:0] col_pin,
  input  logic [ROW_BITS-1:0] ref_ptr,
  output logic                in_ras,
  output cyc_kind_t           cur_kind,
  output logic [ROW_BITS-1:0] row_lat,
  output logic [COL_BITS-1:0] col_eff,
  output logic [1:0]          lane_act,
  output logic                cbr_start,
  output logic                hidden_start,
  output logic                rd_hold,
  output logic                cyc_done,
  output cyc_kind_t           cyc_kind,
  output logic [ROW_BITS-1:0] cyc_row
);

  logic [COL_BITS-1:0] col_lat;
  logic                col_held;
  logic                acc_hold;
  logic                cas_any_low;
  logic                cas_idle;
  logic                normal_cyc;

  assign cas_any_low  = ~&cas_s;
  assign cas_idle     = &cas_s;
  assign normal_cyc   = in_ras && (cur_kind == CYC_RAS_ONLY || cur_kind == CYC_ACCESS);
  assign lane_act     = lane_fall & {2{normal_cyc}};
  assign cbr_start    = ras_fall && cas_any_low && !acc_hold;
  assign hidden_start = ras_fall && cas_any_low && acc_hold;
  assign col_eff      = col_held ? col_lat : col_pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_ras   <= 1'b0;
      cur_kind <= CYC_NONE;
      row_lat  <= '0;
      col_lat  <= '0;
      col_held <= 1'b0;
      acc_hold <= 1'b0;
      rd_hold  <= 1'b0;
      cyc_done <= 1'b0;
      cyc_kind <= CYC_NONE;
      cyc_row  <= '0;
    end else begin
      cyc_done <= 1'b0;
      if (ras_fall) begin
        in_ras <= 1'b1;
        if (cas_any_low) begin
          cur_kind <= acc_hold ? CYC_HIDDEN : CYC_CBR;
          row_lat  <= ref_ptr;
        end else begin
          cur_kind <= CYC_RAS_ONLY;
          row_lat  <= row_pin;
        end
      end else if (ras_rise && in_ras) begin
        in_ras   <= 1'b0;
        cyc_done <= 1'b1;
        cyc_kind <= cur_kind;
        cyc_row  <= row_lat;
      end

      if (|lane_act) begin
        cur_kind <= CYC_ACCESS;
        acc_hold <= 1'b1;
        rd_hold  <= we_s;
        if (!col_held) begin
          col_lat  <= col_pin;
          col_held <= 1'b1;
        end
      end else if (cas_idle) begin
        col_held <= 1'b0;
        acc_hold <= 1'b0;
        rd_hold  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dram_cycle_ctrl.sv
module dram_cycle_ctrl
  import dram_cyc_pkg::*;
#(
  parameter  int unsigned ROW_BITS = 3,
  parameter  int unsigned COL_BITS = 3,
  parameter  int unsigned LANE_W   = 8,
  localparam int unsigned ADDR_W   = wider(ROW_BITS, COL_BITS),
  localparam int unsigned DATA_W   = 2 * LANE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_n,
  input  logic                ucas_n,
  input  logic                lcas_n,
  input  logic                we_n,
  input  logic                oe_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   din,
  output logic [DATA_W-1:0]   dq_out,
  output logic [1:0]          dq_oe,
  output logic                cyc_done,
  output logic [2:0]          cyc_kind,
  output logic [ROW_BITS-1:0] cyc_row
);

  logic [2:0]             strb_s;
  logic [1:0]             ctl_s;
  logic [ADDR_W-1:0]      addr_s;
  logic [DATA_W-1:0]      din_s;
  logic                   ras_s, ras_p;
  logic [1:0]             cas_s, cas_p;
  logic                   we_s, oe_s;
  logic                   ras_fall, ras_rise;
  logic [1:0]             lane_fall;
  logic                   in_ras;
  cyc_kind_t              cur_kind;
  cyc_kind_t              kind_w;
  logic [ROW_BITS-1:0]    row_lat;
  logic [COL_BITS-1:0]    col_eff;
  logic [1:0]             lane_act;
  logic                   cbr_start, hidden_start;
  logic                   rd_hold;
  logic [ROW_BITS-1:0]    ref_ptr;

  dram_sync_pipe #(.W(3), .RST_VAL(1'b1)) u_strb_sync (
    .clk(clk), .rst_n(rst_n), .d({ras_n, ucas_n, lcas_n}), .q(strb_s)
  );

  dram_sync_pipe #(.W(2), .RST_VAL(1'b1)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({we_n, oe_n}), .q(ctl_s)
  );

  dram_sync_pipe #(.W(ADDR_W + DATA_W), .RST_VAL(1'b0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({addr, din}), .q({addr_s, din_s})
  );

  assign ras_s = strb_s[2];
  assign cas_s = strb_s[1:0];
  assign we_s  = ctl_s[1];
  assign oe_s  = ctl_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_p <= 1'b1;
      cas_p <= 2'b11;
    end else begin
      ras_p <= ras_s;
      cas_p <= cas_s;
    end
  end

  assign ras_fall  = ras_p & ~ras_s;
  assign ras_rise  = ~ras_p & ras_s;
  assign lane_fall = cas_p & ~cas_s;

  dram_cycle_classifier #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_classify (
    .clk          (clk),
    .rst_n        (rst_n),
    .ras_fall     (ras_fall),
    .ras_rise     (ras_rise),
    .cas_s        (cas_s),
    .lane_fall    (lane_fall),
    .we_s         (we_s),
    .row_pin      (addr_s[ROW_BITS-1:0]),
    .col_pin      (addr_s[COL_BITS-1:0]),
    .ref_ptr      (ref_ptr),
    .in_ras       (in_ras),
    .cur_kind     (cur_kind),
    .row_lat      (row_lat),
    .col_eff      (col_eff),
    .lane_act     (lane_act),
    .cbr_start    (cbr_start),
    .hidden_start (hidden_start),
    .rd_hold      (rd_hold),
    .cyc_done     (cyc_done),
    .cyc_kind     (kind_w),
    .cyc_row      (cyc_row)
  );

  dram_refresh_ptr #(.ROW_BITS(ROW_BITS)) u_ref_ptr (
    .clk(clk), .rst_n(rst_n), .advance(cbr_start | hidden_start), .ptr(ref_ptr)
  );

  dram_lane_array #(
    .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .LANE_W(LANE_W), .LANES(2)
  ) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .row      (row_lat),
    .col      (col_eff),
    .lane_act (lane_act),
    .wr_en    (~we_s),
    .wdata    (din_s),
    .rdata    (dq_out)
  );

  assign dq_oe    = {2{rd_hold & ~oe_s}} & ~cas_s;
  assign cyc_kind = kind_w;

endmodule

// File: rtl/dram_cycle_ctrl_chk.sv
module dram_cycle_ctrl_chk
  import dram_cyc_pkg::*;
#(
  parameter int unsigned ROW_BITS = 3,
  parameter int unsigned DATA_W   = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ras_rise,
  input logic                in_ras,
  input logic                cbr_start,
  input logic                hidden_start,
  input logic [ROW_BITS-1:0] ref_ptr,
  input cyc_kind_t           cur_kind,
  input logic                cyc_done,
  input logic [1:0]          dq_oe,
  input logic [DATA_W-1:0]   dq_out
);

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cbr_start || hidden_start) |=> ref_ptr == $past(ref_ptr) + 1'b1); // R6

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cbr_start || hidden_start) |=> $stable(ref_ptr)); // R9

  AST_DONE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_rise && in_ras) |=> cyc_done); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_done |=> !cyc_done); // R2

  AST_REFRESH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ras && (cur_kind == CYC_CBR || cur_kind == CYC_RAS_ONLY)) |-> dq_oe == 2'b00); // R5

  AST_HIDDEN_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    hidden_start |=> $stable(dq_out)); // R7

endmodule

bind dram_cycle_ctrl dram_cycle_ctrl_chk #(.ROW_BITS(ROW_BITS), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ras_rise     (ras_rise),
  .in_ras       (in_ras),
  .cbr_start    (cbr_start),
  .hidden_start (hidden_start),
  .ref_ptr      (ref_ptr),
  .cur_kind     (cur_kind),
  .cyc_done     (cyc_done),
  .dq_oe        (dq_oe),
  .dq_out       (dq_out)
);

// File: tb/dram_cycle_ctrl_tb.sv
module dram_cycle_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_BITS   = 3;
  localparam int COL_BITS   = 3;
  localparam int ADDR_W     = 3;
  localparam int ROWS       = 1 << ROW_BITS;
  localparam int COLS       = 1 << COL_BITS;
  localparam int SETTLE     = 4;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dq_out;
  logic [1:0]  dq_oe;
  logic        cyc_done;
  logic [2:0]  cyc_kind;
  logic [ROW_BITS-1:0] cyc_row;

  int n_checks = 0;
  int n_fail   = 0;
  int n_done   = 0;
  int last_kind = 0;
  int last_row  = 0;
  int ptr       = 0;
  bit finished  = 1'b0;
  logic [15:0] model [ROWS*COLS];

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_cycle_ctrl #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .LANE_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .dq_out(dq_out),
    .dq_oe(dq_oe), .cyc_done(cyc_done), .cyc_kind(cyc_kind), .cyc_row(cyc_row)
  );

  always @(negedge clk) begin
    if (rst_n && cyc_done) begin
      n_done    = n_done + 1;
      last_kind = int'(cyc_kind);
      last_row  = int'(cyc_row);
    end
  end

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pattern(input int r, input int c);
    return 16'(r * 4099 + c * 257 + 17);
  endfunction

  task automatic check_report(input string req, input int d0, input int kind, input int row);
    chk_eq(req, "report count", n_done, d0 + 1);
    chk_eq(req, "cycle kind", last_kind, kind);
    chk_eq(req, "cycle row", last_row, row);
  endtask

  task automatic run_access(input int r, input int c, input logic [1:0] lanes, input bit wr,
                            input logic [15:0] wd, output logic [1:0] got_oe,
                            output logic [15:0] got_d);
    int d0;
    d0 = n_done;
    addr = ADDR_W'(r); ras_n = 1'b0; settle();
    addr = ADDR_W'(c); we_n = !wr; oe_n = wr; din = wd; settle();
    ucas_n = !lanes[1]; lcas_n = !lanes[0]; settle();
    got_oe = dq_oe; got_d = dq_out;
    ucas_n = 1'b1; lcas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; settle();
    ras_n = 1'b1; settle();
    check_report("R2", d0, 1, r);
    if (wr) begin
      if (lanes[1]) model[r*COLS+c][15:8] = wd[15:8];
      if (lanes[0]) model[r*COLS+c][7:0]  = wd[7:0];
    end
  endtask

  task automatic read_full(input string req, input int r, input int c);
    logic [1:0]  o;
    logic [15:0] d;
    run_access(r, c, 2'b11, 1'b0, 16'h0, o, d);
    chk_eq(req, "read enable", o, 2'b11);
    chk_eq(req, "read data", d, model[r*COLS+c]);
  endtask

  task automatic run_cbr(input string req, input bit upper);
    int d0;
    d0 = n_done;
    if (upper) ucas_n = 1'b0; else lcas_n = 1'b0;
    settle();
    we_n = 1'b0; oe_n = 1'b0; din = 16'hFFFF; addr = ADDR_W'(7); ras_n = 1'b0; settle();
    chk_eq(req, "enable during column-first refresh", dq_oe, 2'b00);
    ras_n = 1'b1; settle();
    ucas_n = 1'b1; lcas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; settle();
    check_report(req, d0, 3, ptr);
    ptr = (ptr + 1) % ROWS;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0]  o;
    logic [15:0] d;
    logic [15:0] hd;
    int d0;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R1 reset state
    chk_eq("R1", "reset enable", dq_oe, 2'b00);
    chk_eq("R1", "reset done", cyc_done, 0);
    chk_eq("R1", "reset kind", cyc_kind, 0);

    // R3/R4 exhaustive write then read of every word
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        run_access(r, c, 2'b11, 1'b1, pattern(r, c), o, d);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        read_full("R4", r, c);

    // R3 single-lane writes
    run_access(2, 5, 2'b10, 1'b1, 16'hBEEF, o, d);
    chk_eq("R3", "no drive on write", o, 2'b00);
    read_full("R3", 2, 5);
    run_access(6, 1, 2'b01, 1'b1, 16'hC0DE, o, d);
    read_full("R3", 6, 1);

    // R4 single-lane read drives only that lane
    run_access(3, 3, 2'b01, 1'b0, 16'h0, o, d);
    chk_eq("R4", "lower-only enable", o, 2'b01);
    chk_eq("R4", "lower-only data", d[7:0], model[3*COLS+3][7:0]);

    // R4 output enable gating
    d0 = n_done;
    addr = 3'd0; ras_n = 1'b0; settle();
    we_n = 1'b1; oe_n = 1'b1; ucas_n = 1'b0; lcas_n = 1'b0; settle();
    chk_eq("R4", "enable with oe high", dq_oe, 2'b00);
    oe_n = 1'b0; settle();
    chk_eq("R4", "enable with oe low", dq_oe, 2'b11);
    chk_eq("R4", "data with oe low", dq_out, model[0]);
    ucas_n = 1'b1; lcas_n = 1'b1; oe_n = 1'b1; settle();
    ras_n = 1'b1; settle();
    check_report("R2", d0, 1, 0);

    // R8 transparent column latch and page mode
    d0 = n_done;
    addr = 3'd1; ras_n = 1'b0; settle();
    addr = 3'd6; settle();
    addr = 3'd3; we_n = 1'b1; oe_n = 1'b0; settle();
    ucas_n = 1'b0; lcas_n = 1'b0; settle();
    addr = 3'd6; settle();
    chk_eq("R8", "captured column", dq_out, model[1*COLS+3]);
    ucas_n = 1'b1; lcas_n = 1'b1; settle();
    ucas_n = 1'b0; lcas_n = 1'b0; settle();
    chk_eq("R8", "page mode column", dq_out, model[1*COLS+6]);
    ucas_n = 1'b1; lcas_n = 1'b1; oe_n = 1'b1; settle();
    ras_n = 1'b1; settle();
    check_report("R8", d0, 1, 1);

    // R5 row-only refresh ignores write controls
    d0 = n_done;
    addr = 3'd4; ras_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; din = 16'hFFFF; settle();
    chk_eq("R5", "row-only enable", dq_oe, 2'b00);
    ras_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; settle();
    check_report("R5", d0, 2, 4);
    read_full("R5", 4, 0);

    // R1 first column-first refresh uses row 0; R6 ten of them wrap the pointer
    chk_eq("R1", "pointer start", ptr, 0);
    for (int i = 0; i < 10; i++) run_cbr("R6", i[0]);
    read_full("R6", 7, 7);
    read_full("R6", 0, 7);

    // R9 access and row-only cycles leave the pointer
    d0 = n_done;
    addr = 3'd2; ras_n = 1'b0; settle();
    ras_n = 1'b1; settle();
    check_report("R5", d0, 2, 2);
    run_cbr("R9", 1'b1);

    // R7 hidden refresh keeps read data on the pins
    addr = 3'd5; ras_n = 1'b0; settle();
    addr = 3'd2; we_n = 1'b1; oe_n = 1'b0; settle();
    ucas_n = 1'b0; lcas_n = 1'b0; settle();
    hd = dq_out;
    chk_eq("R7", "access data", hd, model[5*COLS+2]);
    d0 = n_done;
    ras_n = 1'b1; settle();
    check_report("R7", d0, 1, 5);
    d0 = n_done;
    addr = 3'd0; ras_n = 1'b0; settle();
    chk_eq("R7", "hidden enable", dq_oe, 2'b11);
    chk_eq("R7", "hidden data", dq_out, hd);
    ras_n = 1'b1; settle();
    check_report("R7", d0, 4, ptr);
    ptr = (ptr + 1) % ROWS;
    ucas_n = 1'b1; lcas_n = 1'b1; oe_n = 1'b1; settle();
    chk_eq("R7", "released enable", dq_oe, 2'b00);
    run_cbr("R7", 1'b0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule